// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status Controller

This block keeps the interrupt status word of a descriptor-driven Ethernet DMA engine. It also holds the few pieces of control state that follow from those interrupts. The DMA engine, the receive and transmit state machines and the bus logic signal events as single-cycle pulses: process stopped, jabber, underflow, descriptor unavailable, watchdog, timer, frame received, and three kinds of bus failure. Each pulse latches a bit in the status word. Software clears a bit by writing a one to it.

A summary bit collects the abnormal conditions. Frame completion is not one of them. Any bus failure is fatal. It drops the bus-enable output and records which kind of failure came first. Only a software reset restores bus access.

Two events suspend a process. A missing receive descriptor suspends the receive process, which resumes on a poll demand or on the next recognised frame. A transmit underflow suspends the transmit process. The underflow is also reported as a one-cycle error flag towards the descriptor write-back path.

Top module: `eth_irq_status`

## Requirements
- R1: An event pulse sets its status bit at the next rising clock edge, and the bit then stays set. The positions are: transmit stopped bit 1, jabber bit 3, transmit underflow bit 5, frame received bit 6, receive descriptor unavailable bit 7, receive stopped bit 8, receive watchdog bit 9, timer bit 11.
- R2: Bit 15 of the status word and the `abnSummary` output are high exactly when any of bits 1, 3, 5, 7, 8, 9, 11 or 13 is set. Bit 6 does not contribute.
- R3: A cycle with `clrWrite` high clears every latched bit (1, 3, 5, 6, 7, 8, 9, 11, 13) whose `clrData` bit is 1, and leaves the bits written with 0 unchanged. An event in the same cycle as its clear leaves the bit set. Writes to bit 15 have no effect.
- R4: A parity error, master abort or target abort sets bit 13. The first such error since reset stores a code in bits 25:23: 3'b000 parity, 3'b001 master abort, 3'b010 target abort. Simultaneous errors take the code in that priority order. Later errors do not change the code.
- R5: `busEnable` goes low at the edge after a bus error and stays low until a software reset, even if bit 13 is cleared.
- R6: A descriptor-unavailable pulse sets `rxSuspended`. A poll demand or a recognised-frame pulse clears it. A new descriptor-unavailable pulse in the same cycle as a resume keeps it set.
- R7: A transmit underflow pulse sets `txSuspended` until software reset. It also raises `underflowFlag` for exactly the one cycle after the edge.
- R8: Reserved bit positions read 0. Writes to them and to the code field have no effect.
- R9: `swReset` (or `rst_n` low) clears the status word, the code, both suspended flags and `underflowFlag`, and sets `busEnable`. A software reset overrides events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swReset | input | 1 | Software reset pulse |
| evTxStop | input | 1 | Transmit process stopped |
| evJabber | input | 1 | Transmit jabber timeout |
| evTxUnder | input | 1 | Transmit FIFO underflow |
| evRxNoDesc | input | 1 | Receive descriptor unavailable |
| evRxStop | input | 1 | Receive process stopped |
| evRxWdog | input | 1 | Receive watchdog timeout |
| evGpTimer | input | 1 | General-purpose timer timeout |
| evRxDone | input | 1 | Frame reception completed |
| evParity | input | 1 | Bus parity error |
| evMasterAbort | input | 1 | Bus master abort |
| evTargetAbort | input | 1 | Bus target abort |
| rxPollDemand | input | 1 | Receive poll demand |
| rxFrameSeen | input | 1 | New recognised frame |
| clrWrite | input | 1 | Write-one-to-clear strobe |
| clrData | input | 32 | Write-one-to-clear data |
| statusWord | output | 32 | Status word with summary and error code |
| abnSummary | output | 1 | Abnormal summary |
| busEnable | output | 1 | Bus access permitted |
| txSuspended | output | 1 | Transmit process suspended |
| rxSuspended | output | 1 | Receive process suspended |
| underflowFlag | output | 1 | Underflow error flag for descriptor write-back |

## Verification
The bench targets these corner cases:
- **Event and clear in the same cycle.** A design that lets the clear win loses an interrupt.
- **Clearing bit 13 after a bus error.** A lockout tied to the status bit would re-enable the bus too early.
- **Simultaneous and repeated bus errors.** A wrong priority or a code that is overwritten reports the wrong culprit.
- **Frame received.** Counting bit 6 in the summary raises a false abnormal interrupt.
- **Both receive resume paths, and a suspend that coincides with a resume.** A design that honours only one path, or lets the resume win, leaves the receiver in the wrong state.

// File: rtl/ethirq_pkg.sv
package ethirq_pkg;
  localparam int WORD_W   = 32;
  localparam int CODE_W   = 3;
  localparam int CODE_LSB = 23;
  localparam int NUM_EV   = 8;

  localparam int BIT_FATAL = 13;
  localparam int BIT_SUM   = 15;
  localparam int BIT_DONE  = 6;

  // event vector order: txStop, jabber, txUnder, rxNoDesc, rxStop, rxWdog, gpTimer, rxDone
  localparam int IDX_TXUNDER  = 2;
  localparam int IDX_RXNODESC = 3;
  localparam int EV_POS [NUM_EV] = '{1, 3, 5, 7, 8, 9, 11, 6};

  typedef enum logic [CODE_W-1:0] {
    ERR_PARITY = 3'b000,
    ERR_MASTER = 3'b001,
    ERR_TARGET = 3'b010
  } bus_err_e;

  function automatic logic [WORD_W-1:0] latchMask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_EV; i++) m[EV_POS[i]] = 1'b1;
    m[BIT_FATAL] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] abnMask();
    logic [WORD_W-1:0] m;
    m = latchMask();
    m[BIT_DONE] = 1'b0;
    return m;
  endfunction

  typedef struct packed {
    logic [WORD_W-1:0] setMask;
    logic [WORD_W-1:0] clrMask;
    logic              softClr;
    logic              codeLoad;
    logic [CODE_W-1:0] codeVal;
  } stat_strobe_t;
endpackage

// File: rtl/ethirq_ctrl.sv
module ethirq_ctrl
  import ethirq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     swReset,
  input  logic [NUM_EV-1:0]        evVec,
  input  logic                     evParity,
  input  logic                     evMasterAbort,
  input  logic                     evTargetAbort,
  input  logic                     rxPollDemand,
  input  logic                     rxFrameSeen,
  input  logic                     clrWrite,
  input  logic [WORD_W-1:0]        clrData,
  output stat_strobe_t             strobe,
  output logic                     busEnable,
  output logic                     txSuspended,
  output logic                     rxSuspended,
  output logic                     underflowFlag
);
  localparam logic [WORD_W-1:0] LATCH_M = latchMask();

  logic fatalNow;
  logic codeHeld;
  logic [WORD_W-1:0] setVec;
  bus_err_e errSel;

  assign fatalNow = evParity | evMasterAbort | evTargetAbort;

  always_comb begin
    setVec = '0;
    for (int i = 0; i < NUM_EV; i++) setVec[EV_POS[i]] = evVec[i];
    setVec[BIT_FATAL] = fatalNow;
  end

  always_comb begin
    if (evParity)           errSel = ERR_PARITY;
    else if (evMasterAbort) errSel = ERR_MASTER;
    else                    errSel = ERR_TARGET;
  end

  always_comb begin
    strobe.setMask  = setVec;
    strobe.clrMask  = clrWrite ? (clrData & LATCH_M) : '0;
    strobe.softClr  = swReset;
    strobe.codeLoad = fatalNow & ~codeHeld & ~swReset;
    strobe.codeVal  = errSel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codeHeld      <= 1'b0;
      busEnable     <= 1'b1;
      txSuspended   <= 1'b0;
      rxSuspended   <= 1'b0;
      underflowFlag <= 1'b0;
    end else if (swReset) begin
      codeHeld      <= 1'b0;
      busEnable     <= 1'b1;
      txSuspended   <= 1'b0;
      rxSuspended   <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      if (fatalNow) begin
        codeHeld  <= 1'b1;
        busEnable <= 1'b0;
      end
      if (evVec[IDX_TXUNDER]) txSuspended <= 1'b1;
      underflowFlag <= evVec[IDX_TXUNDER];
      if (evVec[IDX_RXNODESC])              rxSuspended <= 1'b1;
      else if (rxPollDemand || rxFrameSeen) rxSuspended <= 1'b0;
    end
  end

  a_r5_lockout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busEnable && !swReset) |=> !busEnable);
  a_r5_fatal_drops_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (fatalNow && !swReset) |=> !busEnable);
  a_r6_rx_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (evVec[IDX_RXNODESC] && !swReset) |=> rxSuspended);
  a_r7_tx_suspend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (txSuspended && !swReset) |=> txSuspended);
  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    swReset |=> (busEnable && !rxSuspended && !txSuspended && !underflowFlag));
endmodule

// File: rtl/ethirq_dpath.sv
module ethirq_dpath
  import ethirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  stat_strobe_t      strobe,
  output logic [WORD_W-1:0] statusWord,
  output logic              abnSummary
);
  localparam logic [WORD_W-1:0] LATCH_M = latchMask();
  localparam logic [WORD_W-1:0] ABN_M   = abnMask();

  logic [WORD_W-1:0] statBits;
  logic [CODE_W-1:0] errCode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statBits <= '0;
      errCode  <= '0;
    end else if (strobe.softClr) begin
      statBits <= '0;
      errCode  <= '0;
    end else begin
      statBits <= ((statBits & ~strobe.clrMask) | strobe.setMask) & LATCH_M;
      if (strobe.codeLoad) errCode <= strobe.codeVal;
    end
  end

  assign abnSummary = |(statBits & ABN_M);

  always_comb begin
    statusWord = statBits;
    statusWord[BIT_SUM] = abnSummary;
    statusWord[CODE_LSB +: CODE_W] = errCode;
  end

  a_r1_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.softClr && strobe.clrMask == '0) |=> ((statBits & $past(statBits)) == $past(statBits)));
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.softClr && strobe.setMask[BIT_FATAL]) |=> statBits[BIT_FATAL]);
  a_r4_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.softClr && !strobe.codeLoad) |=> $stable(errCode));
endmodule

// File: rtl/eth_irq_status.sv
module eth_irq_status
  import ethirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swReset,
  input  logic              evTxStop,
  input  logic              evJabber,
  input  logic              evTxUnder,
  input  logic              evRxNoDesc,
  input  logic              evRxStop,
  input  logic              evRxWdog,
  input  logic              evGpTimer,
  input  logic              evRxDone,
  input  logic              evParity,
  input  logic              evMasterAbort,
  input  logic              evTargetAbort,
  input  logic              rxPollDemand,
  input  logic              rxFrameSeen,
  input  logic              clrWrite,
  input  logic [WORD_W-1:0] clrData,
  output logic [WORD_W-1:0] statusWord,
  output logic              abnSummary,
  output logic              busEnable,
  output logic              txSuspended,
  output logic              rxSuspended,
  output logic              underflowFlag
);
  logic [NUM_EV-1:0] evVec;
  stat_strobe_t strobe;

  assign evVec = {evRxDone, evGpTimer, evRxWdog, evRxStop,
                  evRxNoDesc, evTxUnder, evJabber, evTxStop};

  ethirq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .swReset(swReset), .evVec(evVec),
    .evParity(evParity), .evMasterAbort(evMasterAbort), .evTargetAbort(evTargetAbort),
    .rxPollDemand(rxPollDemand), .rxFrameSeen(rxFrameSeen),
    .clrWrite(clrWrite), .clrData(clrData), .strobe(strobe),
    .busEnable(busEnable), .txSuspended(txSuspended),
    .rxSuspended(rxSuspended), .underflowFlag(underflowFlag)
  );

  ethirq_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .statusWord(statusWord), .abnSummary(abnSummary)
  );

  a_r2_summary_bit: assert property (@(posedge clk) disable iff (!rst_n)
    statusWord[BIT_SUM] == abnSummary);
  a_r1_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (evJabber && !swReset) |=> statusWord[3]);
endmodule

// File: tb/eth_irq_status_test.sv
module eth_irq_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;
  // {events[7:0], clr, clrData[15:0], expected[15:0]}
  // events: 0 txStop,1 jabber,2 txUnder,3 rxNoDesc,4 rxStop,5 rxWdog,6 gpTimer,7 rxDone
  localparam logic [40:0] VEC [NV] = '{
    {8'h80, 1'b0, 16'h0000, 16'h0040},
    {8'h01, 1'b0, 16'h0000, 16'h8042},
    {8'h00, 1'b1, 16'h0002, 16'h0040},
    {8'h42, 1'b0, 16'h0000, 16'h8848},
    {8'h00, 1'b1, 16'h8000, 16'h8848},
    {8'h00, 1'b1, 16'h0808, 16'h0040},
    {8'h04, 1'b1, 16'h0020, 16'h8060},
    {8'h00, 1'b1, 16'hFFFF, 16'h0000},
    {8'h38, 1'b0, 16'h0000, 16'h8380},
    {8'h00, 1'b1, 16'h0100, 16'h8280},
    {8'h00, 1'b1, 16'h0280, 16'h0000},
    {8'hFF, 1'b0, 16'h0000, 16'h8BEA},
    {8'h00, 1'b1, 16'h0040, 16'h8BAA},
    {8'h00, 1'b1, 16'hFFFF, 16'h0000}
  };

  logic clk = 0, rst_n = 0, swReset = 0;
  logic evTxStop = 0, evJabber = 0, evTxUnder = 0, evRxNoDesc = 0;
  logic evRxStop = 0, evRxWdog = 0, evGpTimer = 0, evRxDone = 0;
  logic evParity = 0, evMasterAbort = 0, evTargetAbort = 0;
  logic rxPollDemand = 0, rxFrameSeen = 0, clrWrite = 0;
  logic [31:0] clrData = '0;
  logic [31:0] statusWord;
  logic abnSummary, busEnable, txSuspended, rxSuspended, underflowFlag;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_irq_status uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    {evTxStop, evJabber, evTxUnder, evRxNoDesc, evRxStop, evRxWdog, evGpTimer, evRxDone} = '0;
    {evParity, evMasterAbort, evTargetAbort, rxPollDemand, rxFrameSeen, clrWrite, swReset} = '0;
    clrData = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    quiet();
  endtask

  task automatic softReset();
    swReset = 1;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset status", statusWord, 32'h0);
    chk("R9 reset busEnable", {31'b0, busEnable}, 32'h1);
    chk("R9 reset suspends", {30'b0, txSuspended, rxSuspended}, 32'h0);

    // table walk: R1 R2 R3
    for (int i = 0; i < NV; i++) begin
      {evRxDone, evGpTimer, evRxWdog, evRxStop, evRxNoDesc, evTxUnder, evJabber, evTxStop} = VEC[i][40:33];
      clrWrite = VEC[i][32];
      clrData  = {16'h0, VEC[i][31:16]};
      step();
      chk($sformatf("R1/R2/R3 vector %0d", i), statusWord, {16'h0, VEC[i][15:0]});
      chk($sformatf("R2 summary vector %0d", i), {31'b0, abnSummary}, {31'b0, VEC[i][15]});
    end
    softReset();

    // R4 R5: master abort, later target abort, clear fatal bit
    evMasterAbort = 1; step();
    chk("R4 master abort code", statusWord, 32'h0080A000);
    chk("R5 bus off", {31'b0, busEnable}, 32'h0);
    evTargetAbort = 1; step();
    chk("R4 code kept", statusWord, 32'h0080A000);
    clrWrite = 1; clrData = 32'h0000_2000; step();
    chk("R3 fatal cleared", statusWord, 32'h0080_0000);
    chk("R5 bus stays off", {31'b0, busEnable}, 32'h0);
    clrWrite = 1; clrData = 32'hFFFF_FFFF; step();
    chk("R8 reserved and code unwritable", statusWord, 32'h0080_0000);
    softReset();
    chk("R9 soft reset status", statusWord, 32'h0);
    chk("R9 soft reset bus", {31'b0, busEnable}, 32'h1);

    // R4 priority: parity with target abort
    evParity = 1; evTargetAbort = 1; step();
    chk("R4 parity priority", statusWord, 32'h0000A000);
    softReset();
    evTargetAbort = 1; step();
    chk("R4 target abort code", statusWord, 32'h0100A000);
    softReset();

    // R6 receive suspension and resume
    evRxNoDesc = 1; step();
    chk("R6 suspend", {31'b0, rxSuspended}, 32'h1);
    rxPollDemand = 1; step();
    chk("R6 resume on poll", {31'b0, rxSuspended}, 32'h0);
    evRxNoDesc = 1; step();
    step();
    chk("R6 suspend held", {31'b0, rxSuspended}, 32'h1);
    rxFrameSeen = 1; step();
    chk("R6 resume on frame", {31'b0, rxSuspended}, 32'h0);
    evRxNoDesc = 1; rxPollDemand = 1; step();
    chk("R6 suspend beats resume", {31'b0, rxSuspended}, 32'h1);
    softReset();

    // R7 underflow
    evTxUnder = 1; step();
    chk("R7 underflow flag", {31'b0, underflowFlag}, 32'h1);
    chk("R7 tx suspended", {31'b0, txSuspended}, 32'h1);
    step();
    chk("R7 flag one cycle", {31'b0, underflowFlag}, 32'h0);
    chk("R7 tx stays suspended", {31'b0, txSuspended}, 32'h1);

    // R9 soft reset overrides concurrent events
    swReset = 1; evJabber = 1; evParity = 1; evRxNoDesc = 1; evTxUnder = 1; step();
    chk("R9 override status", statusWord, 32'h0);
    chk("R9 override flags", {28'b0, busEnable, txSuspended, rxSuspended, underflowFlag}, 32'h8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule